// File: doc/BRIEF.md
# PLL Power-Up and Retune Sequencer

This block owns the three-bit mode word of a phase-locked loop and walks it through a fixed, timed order when the loop is started, stopped or retuned. Starting goes in four steps. The bypass is released first. After a minimum settling interval the loop reset is released. The block then waits for lock, either on a synchronized lock flag with a timeout or for a fixed interval when no lock flag exists. Only then is the clock output switched on. Stopping clears all three bits in a single cycle. A retune on a running loop is always a full stop, then a register update, then a complete restart.

The block also holds the integer multiplier and the VCO band bit derived from it. The band bit is set when the multiplier exceeds a low-band ceiling. It also holds the fractional numerator and denominator, which are forced to integer mode once before the first start. At reset the block takes a mode word handed over by boot firmware (`boot_mode`) and settles it. A loop that is fully on and locked keeps running. A loop that is fully on but not locked is shut down and configured. All delays are counted in clock cycles derived from `CLK_FREQ_HZ` and microsecond parameters.

Top module: `pll_seq`

## Requirements
- R1: The mode word holds output-enable in bit 0, bypass-release in bit 1 and reset-release in bit 2. A start moves it through 000, 010, 110 and 111 in that order. While reset is held it reads 000, the lock-timeout flag is 0, the configuration-done flag is 0, and both fractional registers read all ones.
- R2: A start request is acted on only when the sequencer is idle and the mode word is 000. Otherwise it is ignored and the mode word is left unchanged. When requests coincide, a stop request wins over a retune request, and a retune request wins over a start request.
- R3: The mode word holds 010 for exactly BYP_CYC = (CLK_FREQ_HZ/1e6)*BYPASS_US cycles before reset-release is set.
- R4: With a lock flag present, the flag passes through a two-flop synchronizer. The mode word becomes 111 three cycles after `lock_in` rises during the lock wait, and the lock wins in the last cycle of the timeout window.
- R5: If no synchronized lock arrives within TMO_CYC = (CLK_FREQ_HZ/1e6)*LOCK_TIMEOUT_US cycles of the lock wait, `lock_timeout_err` is set and the mode word stays at 110, with the output bit clear. The flag stays set until reset.
- R6: With no lock flag (HAS_LOCK=0), the mode word holds 110 for exactly FIX_CYC = (CLK_FREQ_HZ/1e6)*FIXED_WAIT_US cycles before it becomes 111.
- R7: A stop request while idle or running sets the mode word to 000 in the next cycle, from any prior value.
- R8: A retune request while idle loads `retune_mult` into `mult_out` in the next cycle and leaves the mode word unchanged.
- R9: A retune request while running gives mode 000 with the old multiplier one cycle later. One cycle after that the new multiplier and band are loaded and the mode word is 010, and the full start order follows.
- R10: `high_band` is 1 exactly when `mult_out` is greater than LOW_BAND_MAX.
- R11: The configuration load sets `frac_num` to 0, `frac_den` to 1 and `cfg_done` to 1. `cfg_done` is 1 whenever bypass-release rises.
- R12: `output_valid` is 1 exactly when all three mode bits are 1.
- R13: At start-up `boot_mode` is captured, and the decision follows three cycles after reset release. A fully-on, locked word keeps running without the configuration load. A fully-on, unlocked word is cleared to 000 and configured. Any other word is kept and configured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_mode | input | 3 | Mode word left by boot firmware, captured after reset |
| enable_req | input | 1 | Start request, one-cycle pulse |
| disable_req | input | 1 | Stop request, one-cycle pulse |
| retune_req | input | 1 | Retune request, one-cycle pulse |
| retune_mult | input | MULT_W | New integer multiplier |
| lock_in | input | 1 | Asynchronous lock flag from the loop |
| mode_bits | output | 3 | Mode word: bit 2 reset-release, bit 1 bypass-release, bit 0 output |
| mult_out | output | MULT_W | Integer multiplier register |
| high_band | output | 1 | VCO high-band select |
| frac_num | output | FRAC_W | Fractional numerator register |
| frac_den | output | FRAC_W | Fractional denominator register |
| cfg_done | output | 1 | Integer-mode configuration has been loaded |
| output_valid | output | 1 | Loop fully on |
| lock_timeout_err | output | 1 | Sticky lock timeout flag |

## Verification
A request sampled at a rising edge shows on `mode_bits` and the registers at the next falling edge. The bench drives every pulse on a falling edge and reads every result one falling edge later. Phase lengths are counted in falling edges while a given mode word is held and compared with BYP_CYC, FIX_CYC or lock delay plus three. Lock delays are swept up to both sides of the timeout edge. The timeout flag is read in the last cycle before it is due and in the cycle it is due. Start-up results are read a fixed ten cycles after reset release, which is well past the three-cycle decision point.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    typedef enum logic [2:0] {
        S_BOOT,
        S_PROBE,
        S_IDLE,
        S_BYP,
        S_LOCK,
        S_RUN,
        S_RETUNE
    } seq_state_t;

    localparam logic [2:0] MODE_OFF    = 3'b000;
    localparam logic [2:0] MODE_BYPREL = 3'b010;
    localparam logic [2:0] MODE_RSTREL = 3'b110;
    localparam logic [2:0] MODE_ON     = 3'b111;

endpackage

// File: rtl/pll_seq_sync.sv
module pll_seq_sync #(
    parameter bit HAS_LOCK = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_in,
    output logic lock_ok
);
    generate
        if (HAS_LOCK) begin : g_sync
            logic [1:0] sh;
            always_ff @(posedge clk) begin
                if (!rst_n) sh <= 2'b00;
                else        sh <= {sh[0], lock_in};
            end
            assign lock_ok = sh[1];
        end else begin : g_none
            assign lock_ok = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/pll_seq_cfg.sv
module pll_seq_cfg #(
    parameter int MULT_W       = 8,
    parameter int FRAC_W       = 16,
    parameter int LOW_BAND_MAX = 40,
    parameter int MULT_RESET   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_cfg,
    input  logic              load_mult,
    input  logic [MULT_W-1:0] mult_in,
    output logic [FRAC_W-1:0] frac_num,
    output logic [FRAC_W-1:0] frac_den,
    output logic              cfg_done,
    output logic [MULT_W-1:0] mult,
    output logic              high_band
);
    localparam logic [MULT_W-1:0] LOW_LIM  = MULT_W'(LOW_BAND_MAX);
    localparam logic [MULT_W-1:0] MULT_RST = MULT_W'(MULT_RESET);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frac_num  <= '1;
            frac_den  <= '1;
            cfg_done  <= 1'b0;
            mult      <= MULT_RST;
            high_band <= (MULT_RST > LOW_LIM);
        end else begin
            if (load_cfg) begin
                frac_num <= '0;
                frac_den <= FRAC_W'(1);
                cfg_done <= 1'b1;
            end
            if (load_mult) begin
                mult      <= mult_in;
                high_band <= (mult_in > LOW_LIM);
            end
        end
    end
endmodule

// File: rtl/pll_seq.sv
module pll_seq
    import pll_seq_pkg::*;
#(
    parameter int unsigned CLK_FREQ_HZ     = 200_000_000,
    parameter int unsigned BYPASS_US       = 10,
    parameter int unsigned FIXED_WAIT_US   = 60,
    parameter int unsigned LOCK_TIMEOUT_US = 100_000,
    parameter bit          HAS_LOCK        = 1'b1,
    parameter int          MULT_W          = 8,
    parameter int          FRAC_W          = 16,
    parameter int          LOW_BAND_MAX    = 40,
    parameter int          MULT_RESET      = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        boot_mode,
    input  logic              enable_req,
    input  logic              disable_req,
    input  logic              retune_req,
    input  logic [MULT_W-1:0] retune_mult,
    input  logic              lock_in,
    output logic [2:0]        mode_bits,
    output logic [MULT_W-1:0] mult_out,
    output logic              high_band,
    output logic [FRAC_W-1:0] frac_num,
    output logic [FRAC_W-1:0] frac_den,
    output logic              cfg_done,
    output logic              output_valid,
    output logic              lock_timeout_err
);
    localparam int unsigned CYC_PER_US = CLK_FREQ_HZ / 1_000_000;
    localparam int unsigned BYP_CYC    = CYC_PER_US * BYPASS_US;
    localparam int unsigned FIX_CYC    = CYC_PER_US * FIXED_WAIT_US;
    localparam int unsigned TMO_CYC    = CYC_PER_US * LOCK_TIMEOUT_US;
    localparam int unsigned WAIT_CYC   = HAS_LOCK ? TMO_CYC : FIX_CYC;
    localparam int unsigned MAX_CYC    = (WAIT_CYC > BYP_CYC) ? WAIT_CYC : BYP_CYC;
    localparam int          CNT_W      = (MAX_CYC < 3) ? 2 : $clog2(MAX_CYC + 1);

    seq_state_t        state, state_d;
    logic [2:0]        mode, mode_d;
    logic [CNT_W-1:0]  cnt, cnt_d;
    logic [MULT_W-1:0] pend, pend_d;
    logic [MULT_W-1:0] mult_src;
    logic              err_set, ld_cfg, ld_mult, lock_ok, wait_done;

    pll_seq_sync #(.HAS_LOCK(HAS_LOCK)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock_in (lock_in),
        .lock_ok (lock_ok)
    );

    pll_seq_cfg #(
        .MULT_W       (MULT_W),
        .FRAC_W       (FRAC_W),
        .LOW_BAND_MAX (LOW_BAND_MAX),
        .MULT_RESET   (MULT_RESET)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_cfg  (ld_cfg),
        .load_mult (ld_mult),
        .mult_in   (mult_src),
        .frac_num  (frac_num),
        .frac_den  (frac_den),
        .cfg_done  (cfg_done),
        .mult      (mult_out),
        .high_band (high_band)
    );

    // Lock wait ends on the synchronized flag, or on the fixed interval without one.
    assign wait_done = HAS_LOCK ? lock_ok : (cnt == CNT_W'(FIX_CYC - 1));

    // Next-state and control strobes
    always_comb begin
        state_d  = state;
        mode_d   = mode;
        cnt_d    = cnt + CNT_W'(1);
        pend_d   = pend;
        mult_src = retune_mult;
        err_set  = 1'b0;
        ld_cfg   = 1'b0;
        ld_mult  = 1'b0;
        unique case (state)
            S_BOOT: begin
                mode_d  = boot_mode;
                cnt_d   = '0;
                state_d = S_PROBE;
            end
            S_PROBE: begin
                if (cnt == CNT_W'(1)) begin
                    cnt_d = '0;
                    if (mode == MODE_ON && lock_ok) begin
                        state_d = S_RUN;
                    end else begin
                        if (mode == MODE_ON) mode_d = MODE_OFF;
                        ld_cfg  = 1'b1;
                        state_d = S_IDLE;
                    end
                end
            end
            S_IDLE: begin
                cnt_d = '0;
                if (disable_req) begin
                    mode_d = MODE_OFF;
                end else if (retune_req) begin
                    ld_mult = 1'b1;
                end else if (enable_req && mode == MODE_OFF) begin
                    ld_cfg  = !cfg_done;
                    mode_d  = MODE_BYPREL;
                    state_d = S_BYP;
                end
            end
            S_BYP: begin
                if (cnt == CNT_W'(BYP_CYC - 1)) begin
                    mode_d  = MODE_RSTREL;
                    cnt_d   = '0;
                    state_d = S_LOCK;
                end
            end
            S_LOCK: begin
                if (wait_done) begin
                    mode_d  = MODE_ON;
                    state_d = S_RUN;
                end else if (HAS_LOCK && cnt == CNT_W'(TMO_CYC - 1)) begin
                    err_set = 1'b1;
                    state_d = S_IDLE;
                end
            end
            S_RUN: begin
                cnt_d = '0;
                if (disable_req) begin
                    mode_d  = MODE_OFF;
                    state_d = S_IDLE;
                end else if (retune_req) begin
                    mode_d  = MODE_OFF;
                    pend_d  = retune_mult;
                    state_d = S_RETUNE;
                end
            end
            S_RETUNE: begin
                mult_src = pend;
                ld_mult  = 1'b1;
                ld_cfg   = !cfg_done;
                mode_d   = MODE_BYPREL;
                cnt_d    = '0;
                state_d  = S_BYP;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_BOOT;
        else        state <= state_d;
    end

    // Output and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode             <= MODE_OFF;
            cnt              <= '0;
            pend             <= '0;
            lock_timeout_err <= 1'b0;
        end else begin
            mode <= mode_d;
            cnt  <= cnt_d;
            pend <= pend_d;
            if (err_set) lock_timeout_err <= 1'b1;
        end
    end

    assign mode_bits    = mode;
    assign output_valid = (mode == MODE_ON);

endmodule

// File: rtl/pll_seq_chk.sv
module pll_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode,
    input logic       cfg_done,
    input logic       lock_timeout_err
);
    // The boot-word capture on the first edge is excluded; checks arm two edges in.
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (!rst_n)              age <= 2'd0;
        else if (age != 2'd2)    age <= age + 2'd1;
    end

    AST_RSTREL_AFTER_BYPREL: assert property (@(posedge clk) disable iff (!rst_n || age != 2'd2)
        $rose(mode[2]) |-> $past(mode[1])); // R3

    AST_OUT_AFTER_RSTREL: assert property (@(posedge clk) disable iff (!rst_n || age != 2'd2)
        $rose(mode[0]) |-> $past(mode[2] && mode[1])); // R1

    AST_STOP_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n || age != 2'd2)
        $fell(mode[1]) |-> (mode == 3'b000)); // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n || age != 2'd2)
        $past(lock_timeout_err) |-> lock_timeout_err); // R5

    AST_ERR_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n || age != 2'd2)
        $rose(lock_timeout_err) |-> (mode == 3'b110)); // R5

    AST_CFG_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n || age != 2'd2)
        $rose(mode[1]) |-> cfg_done); // R11

endmodule

bind pll_seq pll_seq_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .mode             (mode_bits),
    .cfg_done         (cfg_done),
    .lock_timeout_err (lock_timeout_err)
);

// File: tb/pll_seq_tb.sv
`timescale 1ns/1ps
module pll_seq_tb;
    localparam int BYP = 20;   // 2 cycles/us * 10 us
    localparam int FIX = 120;  // 2 cycles/us * 60 us
    localparam int TMO = 200;  // 2 cycles/us * 100 us
    localparam int LOWB = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] boot_mode = 3'b000;
    logic en = 1'b0, dis = 1'b0, rt = 1'b0, lock_in = 1'b0;
    logic [5:0] rt_mult = '0;
    logic en_f = 1'b0, dis_f = 1'b0;
    logic [2:0] mode, mode_f;
    logic [5:0] mult, mult_f;
    logic band, band_f, cfg, cfg_f, valid, valid_f, err, err_f;
    logic [7:0] fnum, fden, fnum_f, fden_f;
    int vectors = 0, misses = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pll_seq #(.CLK_FREQ_HZ(2_000_000), .LOCK_TIMEOUT_US(100), .HAS_LOCK(1'b1),
              .MULT_W(6), .FRAC_W(8), .LOW_BAND_MAX(LOWB), .MULT_RESET(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode), .enable_req(en),
        .disable_req(dis), .retune_req(rt), .retune_mult(rt_mult), .lock_in(lock_in),
        .mode_bits(mode), .mult_out(mult), .high_band(band), .frac_num(fnum),
        .frac_den(fden), .cfg_done(cfg), .output_valid(valid), .lock_timeout_err(err));

    pll_seq #(.CLK_FREQ_HZ(2_000_000), .LOCK_TIMEOUT_US(100), .HAS_LOCK(1'b0),
              .MULT_W(6), .FRAC_W(8), .LOW_BAND_MAX(LOWB), .MULT_RESET(1)) u_dut_fix (
        .clk(clk), .rst_n(rst_n), .boot_mode(3'b000), .enable_req(en_f),
        .disable_req(dis_f), .retune_req(1'b0), .retune_mult(6'd0), .lock_in(1'b0),
        .mode_bits(mode_f), .mult_out(mult_f), .high_band(band_f), .frac_num(fnum_f),
        .frac_den(fden_f), .cfg_done(cfg_f), .output_valid(valid_f), .lock_timeout_err(err_f));

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(input int which);
        case (which)
            0: en = 1'b1;
            1: dis = 1'b1;
            2: rt = 1'b1;
            3: en_f = 1'b1;
            default: dis_f = 1'b1;
        endcase
        @(negedge clk);
        en = 1'b0; dis = 1'b0; rt = 1'b0; en_f = 1'b0; dis_f = 1'b0;
    endtask

    task automatic count_phase(input bit fix, input logic [2:0] m, output int n);
        n = 0;
        while (((fix ? mode_f : mode) == m) && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic do_reset(input logic [2:0] bm, input logic lk);
        @(negedge clk);
        rst_n = 1'b0; boot_mode = bm; lock_in = lk;
        tick(3);
        rst_n = 1'b1;
        tick(10);
    endtask

    // Start with lock arriving d falling edges into the 110 phase.
    task automatic start_with_lock(input int d, input string tag);
        int n;
        pulse(0);
        count_phase(1'b0, 3'b010, n);
        chk({tag, " R3 bypass phase"}, n, BYP);
        n = 0;
        while (mode == 3'b110 && n < 1000) begin
            if (n == d) lock_in = 1'b1;
            n++;
            @(negedge clk);
        end
        chk({tag, " R4 lock phase"}, n, d + 3);
        chk({tag, " R1 mode on"}, int'(mode), 7);
        chk({tag, " R12 valid"}, int'(valid), 1);
    endtask

    initial begin
        int n;
        int dl [5] = '{0, 1, 7, 60, TMO - 3};
        // Reset state R1
        rst_n = 1'b0;
        tick(2);
        chk("R1 reset mode", int'(mode), 0);
        chk("R1 reset frac_num", int'(fnum), 255);
        chk("R1 reset frac_den", int'(fden), 255);
        chk("R1 reset cfg_done", int'(cfg), 0);
        chk("R1 reset err", int'(err), 0);
        rst_n = 1'b1;
        tick(10);
        chk("R13 plain boot mode", int'(mode), 0);
        chk("R11 frac_num", int'(fnum), 0);
        chk("R11 frac_den", int'(fden), 1);
        chk("R11 cfg_done", int'(cfg), 1);

        // Start sweep over lock delays, including the last winning cycle
        foreach (dl[k]) begin
            start_with_lock(dl[k], "sweep");
            pulse(0);
            chk("R2 start while running ignored", int'(mode), 7);
            pulse(1);
            chk("R7 stop from on", int'(mode), 0);
            chk("R12 valid off", int'(valid), 0);
            lock_in = 1'b0;
            tick(4);
        end
        chk("R5 no error after locks", int'(err), 0);

        // Stopped retune: exhaustive multiplier sweep
        for (int m = 0; m < 64; m++) begin
            rt_mult = 6'(m);
            pulse(2);
            chk("R8 stopped retune mult", int'(mult), m);
            chk("R10 band", int'(band), (m > LOWB) ? 1 : 0);
            chk("R8 mode unchanged", int'(mode), 0);
        end

        // Priority: stop beats retune beats start
        rt_mult = 6'd5; en = 1'b1; rt = 1'b1;
        pulse(2);
        chk("R2 retune wins over start", int'(mode), 0);
        chk("R2 retune applied", int'(mult), 5);

        // Running retune
        start_with_lock(3, "retune");
        rt_mult = 6'd50;
        pulse(2);
        lock_in = 1'b0;
        chk("R9 stop first", int'(mode), 0);
        chk("R9 old mult held", int'(mult), 5);
        @(negedge clk);
        chk("R9 new mult", int'(mult), 50);
        chk("R9 new band", int'(band), 1);
        chk("R9 restart", int'(mode), 2);
        count_phase(1'b0, 3'b010, n);
        chk("R9 R3 bypass after retune", n, BYP);
        n = 0;
        while (mode == 3'b110 && n < 1000) begin
            if (n == 4) lock_in = 1'b1;
            n++;
            @(negedge clk);
        end
        chk("R9 R4 relock", n, 7);
        pulse(1);
        lock_in = 1'b0;
        tick(4);

        // Lock timeout: lock arrives one cycle too late
        pulse(0);
        count_phase(1'b0, 3'b010, n);
        chk("R5 bypass", n, BYP);
        for (int i = 0; i <= TMO; i++) begin
            if (i == TMO - 2) lock_in = 1'b1;
            if (i == TMO - 1) chk("R5 err not yet", int'(err), 0);
            if (i == TMO) begin
                chk("R5 err set", int'(err), 1);
                chk("R5 mode held 110", int'(mode), 6);
            end
            @(negedge clk);
        end
        tick(5);
        chk("R5 output stays off", int'(mode), 6);
        pulse(0);
        tick(3);
        chk("R2 start ignored at 110", int'(mode), 6);
        pulse(1);
        lock_in = 1'b0;
        chk("R7 stop from 110", int'(mode), 0);
        tick(4);
        start_with_lock(2, "after-timeout");
        chk("R5 err sticky", int'(err), 1);
        pulse(1);
        lock_in = 1'b0;

        // Fixed-wait variant
        pulse(3);
        count_phase(1'b1, 3'b010, n);
        chk("R3 fixed bypass", n, BYP);
        count_phase(1'b1, 3'b110, n);
        chk("R6 fixed wait", n, FIX);
        chk("R6 fixed on", int'(mode_f), 7);
        chk("R12 fixed valid", int'(valid_f), 1);
        pulse(4);
        chk("R7 fixed stop", int'(mode_f), 0);

        // Start-up decisions
        do_reset(3'b111, 1'b1);
        chk("R13 locked boot keeps running", int'(mode), 7);
        chk("R13 locked boot no cfg", int'(cfg), 0);
        pulse(1);
        lock_in = 1'b0;
        tick(4);
        start_with_lock(2, "first-start");
        chk("R11 cfg on first start", int'(cfg), 1);
        chk("R11 frac_den", int'(fden), 1);
        pulse(1);
        lock_in = 1'b0;
        do_reset(3'b111, 1'b0);
        chk("R13 unlocked boot cleared", int'(mode), 0);
        chk("R13 unlocked boot cfg", int'(cfg), 1);
        do_reset(3'b011, 1'b0);
        chk("R13 partial boot kept", int'(mode), 3);
        chk("R12 partial not valid", int'(valid), 0);
        pulse(0);
        tick(3);
        chk("R2 start ignored at 011", int'(mode), 3);
        pulse(1);
        chk("R7 stop from 011", int'(mode), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule